// File: doc/BRIEF.md
# Wildcard Alarm Comparator and Pin Driver

This block watches a set of live calendar and clock digits supplied by a neighbouring time counter. It compares them against an alarm pattern of eleven 4-bit BCD digits held in its own registers. Any alarm digit that holds 0xF acts as a "don't care". This lets software ask for, say, "minute 54, second 32 of every hour" or "any minute from 10 to 19". When every digit agrees and the alarm is switched on, a coincidence is raised. The block keeps a coincidence flag that either follows the match or latches until software clears it.

The flag drives an active-low alarm pin through a waveform selector. The choices are one of five prescaler tone taps gated by the flag, a single low pulse one 32.768 kHz period long at the start of a match, a steady low level while the flag is set, or the busy signal from the time counter passed straight through. An output-off control holds the pin high. Software reaches all of it through a small write port. Addresses 0 to 10 are the alarm digits, address 11 is the output-select register and address 12 is the control register.

Top module: `wildcard_alarm`

## Requirements
- R1: After reset the pin is high, the flag and match outputs are low, and every alarm digit reads as 0xF. The alarm is switched off, the output is on, and the select register holds 4'b0110 (level waveform, self-clearing flag).
- R2: Digit i of the alarm register lies at time_vec[4i+3:4i]. The digit order is: 0 second units, 1 second tens, 2 minute units, 3 minute tens, 4 hour units, 5 hour tens, 6 day-of-week, 7 day units, 8 day tens, 9 month units, 10 month tens. Digit i is written at address i. match_o rises one clock after every digit either equals its time digit or holds 0xF, provided the alarm is on.
- R3: With all eleven alarm digits at 0xF and the alarm on, match_o stays high for as long as the alarm is on, whatever the time digits are.
- R4: With select bit 3 at 0, the flag sets on the clock where a match begins and clears on the clock where the match ends.
- R5: With select bit 3 at 1, the flag sets when a match begins and stays set after the match ends, until a control write.
- R6: A write to address 12 sets the flag to data bit 1 on that clock (1 forces it, 0 clears it). This write wins over a match that begins in the same clock, and the cleared flag does not set again until a new match begins.
- R7: Control bit 2 at 1 switches the alarm off: match_o stays low and no match can set the flag.
- R8: Select bits 2:0 equal to k, for k from 0 to 4, drive the pin low exactly while the flag is set and tone_taps[k] is high. The taps are 0 = 2048 Hz, 1 = 1024 Hz, 2 = 64 Hz, 3 = 16 Hz, 4 = 1 Hz.
- R9: Select code 3'b101 gives one low pulse per flag rise. The pulse starts at the first tick_32k after the rise and ends at the following tick_32k.
- R10: Select code 3'b110 holds the pin low exactly while the flag is set.
- R11: Select code 3'b111 drives the pin with the inverse of busy_i, whatever the flag is. The flag and the other settings go on working unchanged.
- R12: Control bit 0 at 1 holds the pin high in every waveform mode.
- R13: Writes to addresses 13 to 15 change no state and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address (0-10 digits, 11 select, 12 control) |
| wr_data | input | 4 | Write data |
| time_vec | input | 44 | Live time digits, digit i at bits 4i+3:4i |
| tone_taps | input | 5 | Prescaler tone levels, 2048/1024/64/16/1 Hz |
| tick_32k | input | 1 | One-clock strobe per 32.768 kHz period |
| busy_i | input | 1 | Busy signal from the time counter |
| alarm_n | output | 1 | Active-low alarm pin |
| flag_o | output | 1 | Coincidence flag read-back |
| match_o | output | 1 | Registered coincidence |

## Verification
The collision that matters is a control write and the first cycle of a match landing on the same clock. The bench provokes it by changing a time digit into agreement in exactly the cycle it issues a flag-clear write. It expects the write to win and the flag to stay low through the rest of that match. A reference model updated on every clock, with its own variables and ordering, judges the pin, flag and match outputs on every cycle. The same comparison covers a latched flag that is cleared while the match still holds, and a pulse armed while the tick strobe is active.

// File: rtl/wildcard_alarm_pkg.sv
// Shared types for the wildcard alarm block.
// Assumes 4-bit digits; the select register encoding is fixed by software.
package wildcard_alarm_pkg;

    localparam int NUM_TONES = 5;
    localparam logic [3:0] WILDCARD = 4'hF;

    typedef enum logic [2:0] {
        OUT_T2048 = 3'd0,
        OUT_T1024 = 3'd1,
        OUT_T64   = 3'd2,
        OUT_T16   = 3'd3,
        OUT_T1    = 3'd4,
        OUT_PULSE = 3'd5,
        OUT_LEVEL = 3'd6,
        OUT_BUSY  = 3'd7
    } out_mode_e;

    typedef enum logic [1:0] {
        PL_IDLE  = 2'd0,
        PL_ARMED = 2'd1,
        PL_LOW   = 2'd2
    } pulse_st_e;

    typedef struct packed {
        logic      latched;
        out_mode_e mode;
    } sel_t;

    typedef struct packed {
        logic alarm_off;
        logic out_off;
    } ctrl_t;

endpackage

// File: rtl/alarm_digit_cmp.sv
// Per-digit wildcard comparator: hit is high when each alarm digit equals
// its time digit or holds the wildcard code. Pure combinational logic.
module alarm_digit_cmp #(
    parameter int NUM_DIGITS = 11,
    parameter int DIG_W      = 4
) (
    input  logic [NUM_DIGITS*DIG_W-1:0] alarm_vec,
    input  logic [NUM_DIGITS*DIG_W-1:0] time_vec,
    output logic                        hit
);
    import wildcard_alarm_pkg::*;

    logic [NUM_DIGITS-1:0] dig_ok;

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dig
        logic [DIG_W-1:0] a_d;
        logic [DIG_W-1:0] t_d;
        assign a_d = alarm_vec[g*DIG_W +: DIG_W];
        assign t_d = time_vec[g*DIG_W +: DIG_W];
        // Digit agrees on equality or on the all-ones wildcard.
        always_comb dig_ok[g] = (a_d == t_d) || (a_d == {DIG_W{1'b1}});
    end

    // All digits must agree.
    always_comb hit = &dig_ok;

endmodule

// File: rtl/alarm_flag_ctl.sv
// Coincidence flag: registers the enabled compare result, detects the start
// of a match and keeps the flag in self-clearing or latched style.
// Assumes control writes are single-cycle strobes and take priority.
module alarm_flag_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic alarm_on,
    input  logic latched,
    input  logic ctrl_wr,
    input  logic ctrl_set,
    output logic match_q,
    output logic flag_q
);

    logic live;
    logic start;

    // Enabled coincidence and its leading edge.
    always_comb begin
        live  = hit && alarm_on;
        start = live && !match_q;
    end

    // Registered coincidence for edge detection and read-back.
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= live;
    end

    // Flag update: control write first, then auto clear, then set on match start.
    always_ff @(posedge clk) begin
        if (!rst_n)                  flag_q <= 1'b0;
        else if (ctrl_wr)            flag_q <= ctrl_set;
        else if (!latched && !live)  flag_q <= 1'b0;
        else if (start)              flag_q <= 1'b1;
    end

    p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && latched && !ctrl_wr) |=> flag_q);

    p_auto_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!latched && !ctrl_wr && !(hit && alarm_on)) |=> !flag_q);

    p_ctrl_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (flag_q == $past(ctrl_set)));

endmodule

// File: rtl/alarm_wave_mux.sv
// Pin waveform selector: tone gating, one-period pulse, steady level or
// busy pass-through, with an output-off override holding the pin high.
// Assumes tick_32k is a one-clock strobe and tone taps are square levels.
module alarm_wave_mux
    import wildcard_alarm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flag_q,
    input  out_mode_e            mode,
    input  logic                 out_off,
    input  logic [NUM_TONES-1:0] tone_taps,
    input  logic                 tick_32k,
    input  logic                 busy_i,
    output logic                 pin_n
);

    logic      flag_d;
    pulse_st_e pst;
    logic      tone_bit;

    // Delayed flag for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_d <= 1'b0;
        else        flag_d <= flag_q;
    end

    // Pulse sequencer: arm on flag rise, go low on next tick, end on the one after.
    always_ff @(posedge clk) begin
        if (!rst_n) pst <= PL_IDLE;
        else begin
            case (pst)
                PL_IDLE:  if (flag_q && !flag_d) pst <= PL_ARMED;
                PL_ARMED: if (tick_32k)          pst <= PL_LOW;
                PL_LOW:   if (tick_32k)          pst <= PL_IDLE;
                default:                         pst <= PL_IDLE;
            endcase
        end
    end

    // Pick the tone tap addressed by the mode code.
    always_comb begin
        tone_bit = 1'b0;
        for (int k = 0; k < NUM_TONES; k++)
            if (mode == out_mode_e'(k)) tone_bit = tone_taps[k];
    end

    // Active-low pin selection.
    always_comb begin
        if (out_off) pin_n = 1'b1;
        else begin
            case (mode)
                OUT_PULSE: pin_n = (pst != PL_LOW);
                OUT_LEVEL: pin_n = !flag_q;
                OUT_BUSY:  pin_n = !busy_i;
                default:   pin_n = !(flag_q && tone_bit);
            endcase
        end
    end

    p_pulse_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pst == PL_IDLE && !(flag_q && !flag_d)) |=> (pst == PL_IDLE));

    p_pin_high_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        out_off |-> pin_n);

    p_busy_route_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_off && mode == OUT_BUSY) |-> (pin_n == !busy_i));

endmodule

// File: rtl/wildcard_alarm.sv
// Top: alarm digit registers, select and control registers, wildcard compare,
// coincidence flag and pin waveform. Assumes DIG_W >= 4 and that addresses
// NUM_DIGITS and NUM_DIGITS+1 fit in ADDR_W bits.
module wildcard_alarm
    import wildcard_alarm_pkg::*;
#(
    parameter int NUM_DIGITS = 11,
    parameter int DIG_W      = 4,
    parameter int ADDR_W     = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DIG_W-1:0]            wr_data,
    input  logic [NUM_DIGITS*DIG_W-1:0] time_vec,
    input  logic [NUM_TONES-1:0]        tone_taps,
    input  logic                        tick_32k,
    input  logic                        busy_i,
    output logic                        alarm_n,
    output logic                        flag_o,
    output logic                        match_o
);

    localparam int VEC_W = NUM_DIGITS * DIG_W;
    localparam logic [ADDR_W-1:0] SEL_ADDR  = ADDR_W'(NUM_DIGITS);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_DIGITS + 1);

    logic [VEC_W-1:0] alarm_vec;
    sel_t             sel_q;
    ctrl_t            ctrl_q;
    logic             ctrl_wr;
    logic             hit;

    always_comb ctrl_wr = wr_en && (wr_addr == CTRL_ADDR);

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_reg
        // Alarm digit storage, reset to wildcard.
        always_ff @(posedge clk) begin
            if (!rst_n)
                alarm_vec[g*DIG_W +: DIG_W] <= {DIG_W{1'b1}};
            else if (wr_en && wr_addr == ADDR_W'(g))
                alarm_vec[g*DIG_W +: DIG_W] <= wr_data;
        end
    end

    // Output select register: latch style and waveform code.
    always_ff @(posedge clk) begin
        if (!rst_n)                         sel_q <= '{latched: 1'b0, mode: OUT_LEVEL};
        else if (wr_en && wr_addr == SEL_ADDR) sel_q <= sel_t'(wr_data[3:0]);
    end

    // Control register: alarm-off and output-off bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '{alarm_off: 1'b1, out_off: 1'b0};
        else if (ctrl_wr) ctrl_q <= '{alarm_off: wr_data[2], out_off: wr_data[0]};
    end

    alarm_digit_cmp #(
        .NUM_DIGITS (NUM_DIGITS),
        .DIG_W      (DIG_W)
    ) i_cmp (
        .alarm_vec  (alarm_vec),
        .time_vec   (time_vec),
        .hit        (hit)
    );

    alarm_flag_ctl i_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .alarm_on (!ctrl_q.alarm_off),
        .latched  (sel_q.latched),
        .ctrl_wr  (ctrl_wr),
        .ctrl_set (wr_data[1]),
        .match_q  (match_o),
        .flag_q   (flag_o)
    );

    alarm_wave_mux i_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .flag_q    (flag_o),
        .mode      (sel_q.mode),
        .out_off   (ctrl_q.out_off),
        .tone_taps (tone_taps),
        .tick_32k  (tick_32k),
        .busy_i    (busy_i),
        .pin_n     (alarm_n)
    );

    p_off_no_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.alarm_off |=> !match_o);

    p_wild_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (&alarm_vec && !ctrl_q.alarm_off) |=> match_o);

endmodule

// File: tb/test_wildcard_alarm.sv
module test_wildcard_alarm;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [3:0]  wr_data = '0;
    logic [43:0] time_vec;
    logic [4:0]  tone_taps = '0;
    logic        tick_32k = 1'b0;
    logic        busy_i = 1'b0;
    logic        alarm_n, flag_o, match_o;

    logic [3:0] tdig [11];
    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    bit  running = 0;
    string phase = "R1";

    // reference model state
    int m_dig [11];
    int m_sel;
    bit m_aoff, m_ooff, m_flag, m_match, m_flagd;
    int m_pst;

    always #5 clk = ~clk;

    always_comb
        for (int i = 0; i < 11; i++) time_vec[i*4 +: 4] = tdig[i];

    wildcard_alarm i_wildcard_alarm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .time_vec(time_vec), .tone_taps(tone_taps),
        .tick_32k(tick_32k), .busy_i(busy_i), .alarm_n(alarm_n),
        .flag_o(flag_o), .match_o(match_o));

    // free-running prescaler-like stimulus, changed just after each edge
    always @(posedge clk) begin
        #1;
        cyc++;
        tone_taps = {cyc[6], cyc[3], cyc[2], cyc[1], cyc[0]};
        tick_32k  = (cyc % 3 == 0);
        busy_i    = cyc[2] ^ cyc[0];
    end

    // behavioural reference, updated from old state on each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 11; i++) m_dig[i] = 15;
            m_sel = 6; m_aoff = 1; m_ooff = 0;
            m_flag = 0; m_match = 0; m_flagd = 0; m_pst = 0;
        end else begin
            bit h, st, nf;
            h = !m_aoff;
            for (int i = 0; i < 11; i++)
                if (m_dig[i] != 15 && m_dig[i] != int'(tdig[i])) h = 0;
            st = h && !m_match;
            nf = m_flag;
            if (wr_en && wr_addr == 12) nf = wr_data[1];
            else if (m_sel < 8 && !h)   nf = 0;
            else if (st)                nf = 1;
            case (m_pst)
                0: if (m_flag && !m_flagd) m_pst = 1;
                1: if (tick_32k) m_pst = 2;
                default: if (tick_32k) m_pst = 0;
            endcase
            m_flagd = m_flag; m_flag = nf; m_match = h;
            if (wr_en) begin
                if (wr_addr < 11) m_dig[wr_addr] = int'(wr_data);
                else if (wr_addr == 11) m_sel = int'(wr_data);
                else if (wr_addr == 12) begin
                    m_aoff = wr_data[2]; m_ooff = wr_data[0];
                end
            end
        end
    end

    function automatic bit exp_pin();
        int md = m_sel % 8;
        if (m_ooff) return 1;
        if (md < 5) return !(m_flag && tone_taps[md]);
        if (md == 5) return !(m_pst == 2);
        if (md == 6) return !m_flag;
        return !busy_i;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (running) begin
            check(alarm_n == exp_pin(), phase, "alarm_n", alarm_n, exp_pin());
            check(flag_o == m_flag, phase, "flag_o", flag_o, m_flag);
            check(match_o == m_match, phase, "match_o", match_o, m_match);
        end
    end

    task automatic wr(int a, int d);
        @(posedge clk); #1;
        wr_en = 1; wr_addr = 4'(a); wr_data = 4'(d);
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic set_t(int i, int v);
        @(posedge clk); #1;
        tdig[i] = 4'(v);
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int pattern [11] = '{5, 4, 0, 3, 8, 0, 3, 5, 2, 2, 1};
        for (int i = 0; i < 11; i++) tdig[i] = 4'(pattern[i]);
        tdig[0] = 4'd4;
        idle(3);
        @(posedge clk); #1; rst_n = 1;
        @(negedge clk);
        check(alarm_n == 1 && flag_o == 0 && match_o == 0, "R1", "reset outputs",
              {alarm_n, flag_o, match_o}, 3'b100);
        running = 1;

        phase = "R13";
        wr(13, 0); wr(14, 15); wr(15, 2);
        idle(3);
        check(alarm_n == 1 && flag_o == 0, "R13", "after ignored writes", {alarm_n, flag_o}, 2'b10);

        phase = "R2";
        for (int i = 0; i < 11; i++) wr(i, pattern[i]);
        wr(12, 0);                    // alarm on, output on, flag clear
        idle(4);
        check(match_o == 0, "R2", "mismatch", match_o, 0);
        set_t(0, 5);
        idle(4);
        @(negedge clk);
        check(match_o == 1 && flag_o == 1, "R2", "full match", {match_o, flag_o}, 2'b11);

        phase = "R4";
        set_t(0, 6);
        idle(2);
        @(negedge clk);
        check(flag_o == 0, "R4", "auto clear", flag_o, 0);

        phase = "R7";
        wr(12, 4);
        set_t(0, 5);
        idle(5);
        @(negedge clk);
        check(match_o == 0 && flag_o == 0, "R7", "alarm off", {match_o, flag_o}, 0);

        phase = "R3";
        for (int i = 0; i < 11; i++) wr(i, 15);
        wr(12, 0);
        for (int s = 0; s < 10; s++) set_t(s % 11, s);
        @(negedge clk);
        check(match_o == 1, "R3", "all wildcard", match_o, 1);

        phase = "R5";
        wr(0, 5);
        wr(11, 4'b1110);
        set_t(0, 6); idle(2);
        set_t(0, 5); idle(3);
        set_t(0, 6); idle(4);
        @(negedge clk);
        check(flag_o == 1 && match_o == 0, "R5", "latched after end", {flag_o, match_o}, 2'b10);

        phase = "R6";
        wr(12, 0); idle(2);
        @(negedge clk);
        check(flag_o == 0, "R6", "clear write", flag_o, 0);
        wr(12, 2); idle(2);
        @(negedge clk);
        check(flag_o == 1, "R6", "force write", flag_o, 1);
        wr(12, 0); idle(2);
        // clear write in the same cycle a match begins
        @(posedge clk); #1;
        tdig[0] = 4'd5; wr_en = 1; wr_addr = 4'd12; wr_data = 4'd0;
        @(posedge clk); #1; wr_en = 0;
        idle(4);
        @(negedge clk);
        check(flag_o == 0 && match_o == 1, "R6", "write beats match start", {flag_o, match_o}, 2'b01);
        set_t(0, 6); idle(2);

        phase = "R8";
        for (int k = 0; k < 5; k++) begin
            wr(11, 8 + k);
            wr(12, 2);
            idle(70);
            wr(12, 0);
            idle(4);
        end

        phase = "R9";
        wr(11, 4'b0101);
        for (int n = 0; n < 3; n++) begin
            set_t(0, 5); idle(3 + n);
            set_t(0, 6); idle(12);
        end

        phase = "R10";
        wr(11, 4'b0110);
        set_t(0, 5); idle(5);
        set_t(0, 6); idle(5);

        phase = "R11";
        wr(11, 4'b0111);
        set_t(0, 5); idle(12);
        @(negedge clk);
        check(flag_o == 1, "R11", "flag still tracks in busy mode", flag_o, 1);
        set_t(0, 6); idle(12);

        phase = "R12";
        wr(11, 4'b1110);
        wr(12, 3);
        set_t(0, 5); idle(6);
        @(negedge clk);
        check(alarm_n == 1 && flag_o == 1, "R12", "output off", {alarm_n, flag_o}, 2'b11);
        wr(11, 4'b0111); idle(10);
        wr(12, 0); idle(4);

        running = 0;
        finish_run();
    end

endmodule